// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block keeps up to eight page requests and compares every decoded teletext page header against them. A request is seven 5-bit bytes. Each byte covers one digit of the header: magazine, page tens, page units, hours tens, hours units, minutes tens or minutes units. Bit 4 of each byte is that digit's enable. A digit with its enable clear plays no part in the comparison, so a request can name a plain page or a page with a particular time sub-code.

The requests are split into two groups of four, and a select input chooses which group is live. When an accepted header satisfies a live, unheld request, the block does two things. It pulses a capture strobe carrying the index of that request's page store. It then streams out a ten-byte record for the received page. The record packs one header nibble into each byte, adds that byte's Hamming error flag, and ends with a found flag and a page-being-looked-for flag.

Headers arrive on a valid/ready stream. While a record is still being sent, the header side is back-pressured (`hdr_ready` low). Record bytes leave on a valid/ready stream: a byte is held stable until `rec_ready` takes it. Request writes use a plain pointer port and are accepted on every cycle.

Top module: `page_req_matcher`

## Requirements
- R1: After reset, every request byte is zero, so HOLD is low. No request is pending, `hdr_ready` is high, and `cap_valid` and `rec_valid` are low.
- R2: A write port loads the request pointer and writes request bytes.
  - `ptr_load` loads the pointer with entry `ptr_entry` and column `ptr_col`. A `ptr_col` of 7 is taken as 0.
  - `req_wr` stores `req_wdata` at the pointer. When both strobes are high in the same cycle, the write uses the newly loaded address.
  - Each write advances the column by one. After column 6 it wraps to column 0 of the same entry.
- R3: Request byte layout, with bit 4 as the digit enable in every column:
  - Column 0: bit 3 = HOLD, bits 2:0 = magazine.
  - Column 1: page tens in bits 3:0.
  - Column 2: page units in bits 3:0.
  - Column 3: hours tens in bits 1:0.
  - Column 4: hours units in bits 3:0.
  - Column 5: minutes tens in bits 2:0.
  - Column 6: minutes units in bits 3:0.
- R4: A digit whose enable bit is 0 never blocks a match, even when its header byte carries a Hamming error.
- R5: An enabled digit matches only when its value equals the header digit and its header byte has no Hamming error.
- R6: A request whose HOLD bit is 0 is held. It produces no capture and no record.
- R7: `grp_sel` = 0 makes entries 0 to 3 live, and `grp_sel` = 1 makes entries 4 to 7 live. Entries outside the live group are never matched. When several live entries match, the lowest index wins.
- R8: After a header is accepted and matches, `cap_valid` is high for exactly one cycle, the cycle after acceptance. In that cycle `cap_store` holds the winning entry index.
- R9: Record streaming and back-pressure:
  - `rec_valid` rises in the same cycle as `cap_valid`.
  - Columns 0 to 9 are sent in order. Each advances on `rec_valid && rec_ready`, and a byte is held stable until it is taken.
  - `hdr_ready` stays low from that cycle until the cycle after column 9 is taken.
- R10: Record layout, bit 4 of columns 0 to 8 = that header byte's Hamming error flag:
  - Columns 0 to 7 carry header nibbles 0 to 7 in bits 3:0 (PU, PT, MU, MT with C4, HU, HT with C5 and C6, C7 to C10, C11 to C14).
  - Column 8 bits 2:0 carry the magazine, error flag from `hdr_err[8]`.
  - Column 9 bits 4:1 are 0.
- R11: FOUND and PBLF flags, with a per-entry pending flag behind PBLF:
  - Column 8 bit 3 (FOUND) is 0 in every record, meaning found.
  - A write to any byte of an entry sets its pending flag, and a match clears it. A write in the same cycle as a match leaves the flag set.
  - Column 9 bit 0 (PBLF) carries the pending flag as it stood before the match.
- R12: A header that matches no live request is accepted and dropped. No capture and no record follow, and `hdr_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_sel | input | 1 | Live request group |
| ptr_load | input | 1 | Load the request write pointer |
| ptr_entry | input | 3 | Entry for pointer load |
| ptr_col | input | 3 | Column for pointer load |
| req_wr | input | 1 | Write one request byte at the pointer |
| req_wdata | input | 5 | Request byte |
| hdr_valid | input | 1 | Header valid |
| hdr_ready | output | 1 | Header ready |
| hdr_nib | input | 32 | Header nibbles 0 to 7, nibble i in bits 4i+3:4i |
| hdr_mag | input | 3 | Header magazine |
| hdr_err | input | 9 | Hamming error per header byte, bit 8 for the magazine |
| cap_valid | output | 1 | Capture strobe |
| cap_store | output | 3 | Page store index for the capture |
| rec_valid | output | 1 | Record byte valid |
| rec_ready | input | 1 | Record byte ready |
| rec_col | output | 4 | Column of the current record byte |
| rec_byte | output | 5 | Record byte |

## Verification
The header is matched combinationally in its acceptance cycle. Because of that, `cap_valid`, `rec_valid` and column 0 appear one clock after the accepting edge, and each later column appears one clock after the handshake that took the previous one. A request write changes the matching result from the very next acceptance. The bench updates its model on each rising edge and compares every output 2 ns later, so each result is judged in the first cycle it is due. Directed scenario checks run after the record stream has drained and `hdr_ready` has returned.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int REQ_BYTES = 7;
  localparam int REC_BYTES = 10;
  localparam int BYTE_W    = 5;
  localparam int NIB_COLS  = 8;
  localparam int MAG_COL   = 8;
  localparam int FLAG_COL  = 9;
  localparam int HDR_ERRS  = 9;
  localparam int COL_W     = $clog2(REQ_BYTES);
  localparam int REC_COL_W = $clog2(REC_BYTES);

  typedef logic [BYTE_W-1:0] rbyte_t;

  typedef struct packed {
    logic [2:0] mag;
    logic [3:0] pt;
    logic [3:0] pu;
    logic [1:0] ht;
    logic [3:0] hu;
    logic [2:0] mt;
    logic [3:0] mu;
  } key_t;
endpackage

// File: rtl/pmr_req_store.sv
module pmr_req_store
  import pmr_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int ENT_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [ENT_W-1:0] ptr_entry,
  input  logic [COL_W-1:0] ptr_col,
  input  logic             wr,
  input  rbyte_t           wdata,
  input  logic             clr,
  input  logic [ENT_W-1:0] clr_idx,
  output rbyte_t           req [ENTRIES][REQ_BYTES],
  output logic [ENTRIES-1:0] pend
);
  logic [ENT_W-1:0] cur_e, eff_e;
  logic [COL_W-1:0] cur_c, eff_c, nxt_c;

  always_comb begin
    eff_e = ptr_load ? ptr_entry : cur_e;
    if (ptr_load) eff_c = (ptr_col >= COL_W'(REQ_BYTES)) ? '0 : ptr_col;
    else          eff_c = cur_c;
    nxt_c = (eff_c == COL_W'(REQ_BYTES - 1)) ? '0 : eff_c + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_e <= '0;
      cur_c <= '0;
      pend  <= '0;
      for (int e = 0; e < ENTRIES; e++)
        for (int c = 0; c < REQ_BYTES; c++)
          req[e][c] <= '0;
    end else begin
      if (ptr_load || wr) begin
        cur_e <= eff_e;
        cur_c <= wr ? nxt_c : eff_c;
      end
      if (clr) pend[clr_idx] <= 1'b0;
      if (wr) begin
        req[eff_e][eff_c] <= wdata;
        pend[eff_e]       <= 1'b1;
      end
    end
  end

  // R2
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ptr_load) |=> (cur_c == (($past(cur_c) == COL_W'(REQ_BYTES - 1)) ? '0 : $past(cur_c) + 1'b1)));

  // R11
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> pend[$past(eff_e)]);
endmodule

// File: rtl/pmr_match.sv
module pmr_match
  import pmr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int GROUP   = 4,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int GSEL_W = $clog2(ENTRIES / GROUP)
) (
  input  rbyte_t              req [ENTRIES][REQ_BYTES],
  input  key_t                key,
  input  logic [REQ_BYTES-1:0] key_err,
  input  logic [GSEL_W-1:0]   grp_sel,
  output logic                hit,
  output logic [ENT_W-1:0]    hit_idx
);
  logic [ENTRIES-1:0] ent_ok;

  function automatic logic dig_ok(rbyte_t rb, logic [3:0] val, logic [3:0] mask, logic err);
    return !rb[4] || (!err && (((rb[3:0] ^ val) & mask) == 4'h0));
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [REQ_BYTES-1:0] dok;
    assign dok[0] = dig_ok(req[e][0], {1'b0, key.mag}, 4'b0111, key_err[0]);
    assign dok[1] = dig_ok(req[e][1], key.pt, 4'b1111, key_err[1]);
    assign dok[2] = dig_ok(req[e][2], key.pu, 4'b1111, key_err[2]);
    assign dok[3] = dig_ok(req[e][3], {2'b00, key.ht}, 4'b0011, key_err[3]);
    assign dok[4] = dig_ok(req[e][4], key.hu, 4'b1111, key_err[4]);
    assign dok[5] = dig_ok(req[e][5], {1'b0, key.mt}, 4'b0111, key_err[5]);
    assign dok[6] = dig_ok(req[e][6], key.mu, 4'b1111, key_err[6]);
    assign ent_ok[e] = (grp_sel == GSEL_W'(e / GROUP)) && req[e][0][3] && (&dok);
  end

  always_comb begin
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (ent_ok[e]) hit_idx = ENT_W'(e);
    hit = |ent_ok;
  end
endmodule

// File: rtl/pmr_rec_out.sv
module pmr_rec_out
  import pmr_pkg::*;
#(
  parameter int ENT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ENT_W-1:0]     start_idx,
  input  logic [4*NIB_COLS-1:0] nib,
  input  logic [2:0]           mag,
  input  logic [HDR_ERRS-1:0]  err,
  input  logic                 pblf_prev,
  input  logic                 rec_ready,
  output logic                 busy,
  output logic                 cap_valid,
  output logic [ENT_W-1:0]     cap_store,
  output logic [REC_COL_W-1:0] rec_col,
  output rbyte_t               rec_byte
);
  rbyte_t rec_q [REC_BYTES];
  rbyte_t rec_d [REC_BYTES];

  always_comb begin
    for (int i = 0; i < NIB_COLS; i++) rec_d[i] = {err[i], nib[4*i +: 4]};
    rec_d[MAG_COL]  = {err[MAG_COL], 1'b0, mag};
    rec_d[FLAG_COL] = {4'b0000, pblf_prev};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rec_col   <= '0;
      cap_valid <= 1'b0;
      cap_store <= '0;
      for (int i = 0; i < REC_BYTES; i++) rec_q[i] <= '0;
    end else begin
      cap_valid <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        rec_col   <= '0;
        cap_valid <= 1'b1;
        cap_store <= start_idx;
        for (int i = 0; i < REC_BYTES; i++) rec_q[i] <= rec_d[i];
      end else if (busy && rec_ready) begin
        if (rec_col == REC_COL_W'(REC_BYTES - 1)) busy <= 1'b0;
        else rec_col <= rec_col + 1'b1;
      end
    end
  end

  assign rec_byte = rec_q[rec_col];

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rec_ready) |=> (busy && $stable(rec_col) && $stable(rec_byte)));

  // R9
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rec_ready && rec_col != REC_COL_W'(REC_BYTES - 1)) |=> (rec_col == $past(rec_col) + 1'b1));

  // R8
  cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);

  // R8
  cap_first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (busy && rec_col == '0));
endmodule

// File: rtl/page_req_matcher.sv
module page_req_matcher
  import pmr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int GROUP   = 4,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int GSEL_W = $clog2(ENTRIES / GROUP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GSEL_W-1:0]     grp_sel,
  input  logic                  ptr_load,
  input  logic [ENT_W-1:0]      ptr_entry,
  input  logic [COL_W-1:0]      ptr_col,
  input  logic                  req_wr,
  input  logic [BYTE_W-1:0]     req_wdata,
  input  logic                  hdr_valid,
  output logic                  hdr_ready,
  input  logic [4*NIB_COLS-1:0] hdr_nib,
  input  logic [2:0]            hdr_mag,
  input  logic [HDR_ERRS-1:0]   hdr_err,
  output logic                  cap_valid,
  output logic [ENT_W-1:0]      cap_store,
  output logic                  rec_valid,
  input  logic                  rec_ready,
  output logic [REC_COL_W-1:0]  rec_col,
  output logic [BYTE_W-1:0]     rec_byte
);
  rbyte_t               req_q [ENTRIES][REQ_BYTES];
  logic [ENTRIES-1:0]   pend;
  key_t                 key;
  logic [REQ_BYTES-1:0] key_err;
  logic                 hit, busy, start;
  logic [ENT_W-1:0]     hit_idx;

  always_comb begin
    key.mag = hdr_mag;
    key.pt  = hdr_nib[7:4];
    key.pu  = hdr_nib[3:0];
    key.ht  = hdr_nib[21:20];
    key.hu  = hdr_nib[19:16];
    key.mt  = hdr_nib[14:12];
    key.mu  = hdr_nib[11:8];
    key_err = {hdr_err[2], hdr_err[3], hdr_err[4], hdr_err[5],
               hdr_err[0], hdr_err[1], hdr_err[MAG_COL]};
  end

  assign hdr_ready = !busy;
  assign start     = hdr_valid && hdr_ready && hit;
  assign rec_valid = busy;

  pmr_req_store #(.ENTRIES(ENTRIES)) i_store (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_entry(ptr_entry),
    .ptr_col(ptr_col), .wr(req_wr), .wdata(req_wdata), .clr(start),
    .clr_idx(hit_idx), .req(req_q), .pend(pend)
  );

  pmr_match #(.ENTRIES(ENTRIES), .GROUP(GROUP)) i_match (
    .req(req_q), .key(key), .key_err(key_err), .grp_sel(grp_sel),
    .hit(hit), .hit_idx(hit_idx)
  );

  pmr_rec_out #(.ENT_W(ENT_W)) i_rec (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(hit_idx),
    .nib(hdr_nib), .mag(hdr_mag), .err(hdr_err), .pblf_prev(pend[hit_idx]),
    .rec_ready(rec_ready), .busy(busy), .cap_valid(cap_valid),
    .cap_store(cap_store), .rec_col(rec_col), .rec_byte(rec_byte)
  );

  // R12
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !hit) |=> (hdr_ready && !cap_valid));
endmodule

// File: tb/test_page_req_matcher.sv
module test_page_req_matcher;
  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_sel = 1'b0, ptr_load = 1'b0, req_wr = 1'b0, hdr_valid = 1'b0, rec_ready = 1'b1;
  logic [2:0] ptr_entry = '0, ptr_col = '0, hdr_mag = '0;
  logic [4:0] req_wdata = '0;
  logic [31:0] hdr_nib = '0;
  logic [8:0] hdr_err = '0;
  logic hdr_ready, cap_valid, rec_valid;
  logic [2:0] cap_store;
  logic [3:0] rec_col;
  logic [4:0] rec_byte;

  page_req_matcher i_page_req_matcher (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cap_seen = 0, last_store = -1;
  logic [4:0] last_b8, last_b9;
  bit bp_mode = 0;

  // behavioural reference
  logic [4:0] m_req [8][7];
  bit m_pend [8];
  int m_pe, m_pc, m_col, m_store;
  bit m_busy, m_cap;
  logic [4:0] m_rec [10];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_hit();
    for (int e = 0; e < 8; e++) begin
      bit ok = 1;
      if ((e / 4) != int'(grp_sel)) continue;
      if (!m_req[e][0][3]) continue;
      if (m_req[e][0][4] && (hdr_err[8] || m_req[e][0][2:0] != hdr_mag)) ok = 0;
      if (m_req[e][1][4] && (hdr_err[1] || m_req[e][1][3:0] != hdr_nib[7:4])) ok = 0;
      if (m_req[e][2][4] && (hdr_err[0] || m_req[e][2][3:0] != hdr_nib[3:0])) ok = 0;
      if (m_req[e][3][4] && (hdr_err[5] || m_req[e][3][1:0] != hdr_nib[21:20])) ok = 0;
      if (m_req[e][4][4] && (hdr_err[4] || m_req[e][4][3:0] != hdr_nib[19:16])) ok = 0;
      if (m_req[e][5][4] && (hdr_err[3] || m_req[e][5][2:0] != hdr_nib[14:12])) ok = 0;
      if (m_req[e][6][4] && (hdr_err[2] || m_req[e][6][3:0] != hdr_nib[11:8])) ok = 0;
      if (ok) return e;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 8; e++) begin
        m_pend[e] = 0;
        for (int c = 0; c < 7; c++) m_req[e][c] = '0;
      end
      m_pe = 0; m_pc = 0; m_busy = 0; m_col = 0; m_cap = 0; m_store = 0;
    end else begin
      int h, ee, ec;
      h = model_hit();
      m_cap = 0;
      if (m_busy && rec_ready) begin
        if (m_col == 9) m_busy = 0; else m_col++;
      end else if (!m_busy && hdr_valid && h >= 0) begin
        m_busy = 1; m_col = 0; m_cap = 1; m_store = h;
        for (int i = 0; i < 8; i++) m_rec[i] = {hdr_err[i], hdr_nib[4*i +: 4]};
        m_rec[8] = {hdr_err[8], 1'b0, hdr_mag};
        m_rec[9] = {4'b0, m_pend[h] ? 1'b1 : 1'b0};
        m_pend[h] = 0;
      end
      ee = ptr_load ? int'(ptr_entry) : m_pe;
      ec = ptr_load ? ((ptr_col == 3'd7) ? 0 : int'(ptr_col)) : m_pc;
      if (req_wr) begin
        m_req[ee][ec] = req_wdata;
        m_pend[ee] = 1;
        ec = (ec == 6) ? 0 : ec + 1;
      end
      m_pe = ee; m_pc = ec;
    end
    #2;
    if (rst_n) begin
      chk("R12 hdr_ready", hdr_ready, !m_busy);
      chk("R9 rec_valid", rec_valid, m_busy);
      chk("R8 cap_valid", cap_valid, m_cap);
      if (m_cap) chk("R7 cap_store", cap_store, m_store);
      if (m_busy) begin
        chk("R9 rec_col", rec_col, m_col);
        chk("R10 rec_byte", rec_byte, m_rec[m_col]);
      end
      if (cap_valid) begin cap_seen++; last_store = cap_store; end
      if (rec_valid && rec_col == 4'd8) last_b8 = rec_byte;
      if (rec_valid && rec_col == 4'd9) last_b9 = rec_byte;
    end
  end

  task automatic wr_at(int e, int c, logic [4:0] d);
    ptr_load = 1; ptr_entry = 3'(e); ptr_col = 3'(c); req_wr = 1; req_wdata = d;
    @(negedge clk); ptr_load = 0; req_wr = 0;
  endtask

  task automatic wr_next(logic [4:0] d);
    req_wr = 1; req_wdata = d; @(negedge clk); req_wr = 0;
  endtask

  task automatic wr_entry(int e, logic [4:0] b0, b1, b2, b3, b4, b5, b6);
    wr_at(e, 0, b0); wr_next(b1); wr_next(b2); wr_next(b3);
    wr_next(b4); wr_next(b5); wr_next(b6);
  endtask

  task automatic send(int mag, int pt, int pu, int hu, logic [8:0] er);
    hdr_mag = 3'(mag);
    hdr_nib = {$urandom} & 32'hFFFF_FFFF;
    hdr_nib[3:0] = 4'(pu); hdr_nib[7:4] = 4'(pt); hdr_nib[19:16] = 4'(hu);
    hdr_err = er; hdr_valid = 1;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk); hdr_valid = 0;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int c0;
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
      forever begin
        @(negedge clk);
        rec_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hdr_ready", hdr_ready, 1);
    chk("R1 cap_valid", cap_valid, 0);
    chk("R1 rec_valid", rec_valid, 0);
    send(3, 2, 5, 0, 0);
    chk("R1 held after reset, no capture", cap_seen, 0);

    // R3 entry 2: magazine 3, page 25, time digits disabled
    wr_entry(2, 5'b11011, 5'b10010, 5'b10101, 5'b00000, 5'b00000, 5'b00000, 5'b00000);
    send(3, 2, 5, 9, 0);
    chk("R8 capture count", cap_seen, 1);
    chk("R8 store index", last_store, 2);
    chk("R11 first PBLF", last_b9, 5'h01);
    chk("R11 FOUND low, magazine", last_b8, 5'h03);
    send(3, 2, 5, 1, 0);
    chk("R11 second PBLF", last_b9, 5'h00);
    c0 = cap_seen;
    send(3, 2, 6, 1, 0);
    chk("R12 no match dropped", cap_seen, c0);
    send(3, 2, 5, 1, 9'h001);
    chk("R5 error on enabled digit", cap_seen, c0);
    send(3, 2, 5, 1, 9'h010);
    chk("R4 error on disabled digit", cap_seen, c0 + 1);
    bp_mode = 1;
    send(3, 2, 5, 4, 9'h100 - 9'h100);
    bp_mode = 0;
    chk("R9 back-pressured record", cap_seen, c0 + 2);

    // R6 HOLD low
    c0 = cap_seen;
    wr_at(2, 0, 5'b10011);
    send(3, 2, 5, 0, 0);
    chk("R6 held entry", cap_seen, c0);
    // R2 wrap from column 6 to 0 restores HOLD
    wr_at(2, 6, 5'b00000);
    wr_next(5'b11011);
    send(3, 2, 5, 0, 0);
    chk("R2 wrap write", cap_seen, c0 + 1);
    chk("R11 PBLF after rewrite", last_b9, 5'h01);
    // R2 column 7 taken as 0
    wr_at(2, 7, 5'b10011);
    send(3, 2, 5, 0, 0);
    chk("R2 column 7 alias", cap_seen, c0 + 1);
    wr_at(2, 0, 5'b11011);

    // R7 groups and priority
    grp_sel = 1;
    c0 = cap_seen;
    send(3, 2, 5, 0, 0);
    chk("R7 other group idle", cap_seen, c0);
    wr_entry(5, 5'b01000, 0, 0, 0, 0, 0, 0);
    send(1, 7, 7, 0, 9'h1FF);
    chk("R7 wildcard entry", last_store, 5);
    wr_entry(4, 5'b11011, 5'b10010, 5'b10101, 0, 0, 0, 0);
    send(3, 2, 5, 0, 0);
    chk("R7 lowest index wins", last_store, 4);
    send(3, 2, 6, 0, 0);
    chk("R7 fallback entry", last_store, 5);
    grp_sel = 0;

    // mixed traffic against the model
    for (int k = 0; k < 300; k++) begin
      bp_mode = ($urandom % 3) == 0;
      grp_sel = 1'($urandom % 2);
      if ($urandom % 4 == 0)
        wr_at($urandom % 8, $urandom % 8, 5'($urandom % 32) | 5'b01000);
      send(($urandom % 2) ? 3 : 5, 2, ($urandom % 2) ? 5 : 6, $urandom % 3,
           (($urandom % 4) == 0) ? 9'($urandom) : 9'h000);
    end
    bp_mode = 0;
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule